// File: doc/BRIEF.md
# Popularity-Threshold Route Cache Promotion Controller

This controller sits next to a two-level route cache, a fast level and a mid level, which is backed by a slow full routing table. Every lookup reports a match event with a prefix index and the level that served the match. For each prefix the controller keeps a match count within the current one-minute window. When a count reaches the promotion threshold, the controller moves the prefix one level up. It issues install, remove, evict and mark commands to the memory managers over a valid/ready command port.

The threshold depends on how full the destination level is. While the destination still has room, a low warm-up value lets the cache fill quickly. Once the destination is full, a high steady-state value applies. A promotion into a full level always starts with the eviction of a victim. The victim is the least popular prefix, and a separate per-level tracker outside this block presents it on an input. The controller keeps its own occupancy counter for each level and handles one promotion at a time.

The sequencer is a state machine with five states:
- `ST_IDLE` accepts match events.
- `ST_EVICT` issues the victim eviction.
- `ST_REMOVE` takes a promoted prefix out of the mid level.
- `ST_INSTALL` writes the prefix into its new level.
- `ST_MARK` sets the cached flag of the prefix in the full table.

A promoting event in `ST_IDLE` moves the machine to `ST_EVICT` when the destination level is full. Otherwise it moves to `ST_REMOVE` for a mid-level source, or to `ST_INSTALL` for a slow-table source. The other transitions are:
- `ST_EVICT` goes to `ST_REMOVE` or `ST_INSTALL`, chosen by the same source rule.
- `ST_REMOVE` goes to `ST_INSTALL`.
- `ST_INSTALL` goes to `ST_IDLE` for a fast-level install, and to `ST_MARK` for a mid-level install.
- `ST_MARK` goes to `ST_IDLE`.

Every command state stays put until `cmd_ready` is high.

Top module: `route_promo_ctrl`

## Requirements
- R1: A slow-table match (`hit_lvl`=2) whose count reaches the mid threshold produces INSTALL (`cmd_op`=0) to mid (`cmd_lvl`=1), followed by MARK (`cmd_op`=3) to the slow table (`cmd_lvl`=2), both for the same index.
- R2: A mid-level match (`hit_lvl`=1) whose count reaches the fast threshold produces REMOVE (`cmd_op`=1) from mid, followed by INSTALL to fast (`cmd_lvl`=0), both for the same index.
- R3: The fast-level threshold is FAST_TH_WARM while the fast level is below capacity and FAST_TH_HOT once it is full. The mid-level threshold is MID_TH_WARM while the mid level is below capacity and MID_TH_HOT once it is full. A count below the threshold issues no command.
- R4: A promotion into a full level first issues EVICT (`cmd_op`=2) for that level, carrying the victim index of that level (`fast_victim` or `mid_victim`, sampled when the match is accepted). Occupancy never exceeds FAST_CAP or MID_CAP.
- R5: Each level has an occupancy count that rises by one on an INSTALL handshake and falls by one on a REMOVE or EVICT handshake. The level counts as full when the count equals its capacity.
- R6: A pulse on `tick_min` clears every match count.
- R7: A promoted prefix's count is cleared at promotion, and a victim's count is cleared at its EVICT handshake.
- R8: `hit_ready` is low while a command sequence is outstanding. A command holds its op, level and index until `cmd_ready` accepts it. After reset `hit_ready` is 1 and `cmd_valid` is 0.
- R9: Matches served by the fast level (`hit_lvl`=0), and the value 3, are not counted and issue no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_min | input | 1 | One-cycle pulse at the start of each counting window |
| hit_valid | input | 1 | Match event valid |
| hit_ready | output | 1 | Match event accepted (idle only) |
| hit_idx | input | IDX_W | Prefix index of the match |
| hit_lvl | input | 2 | Level that served the match: 0 fast, 1 mid, 2 slow |
| fast_victim | input | IDX_W | Least popular prefix in the fast level |
| mid_victim | input | IDX_W | Least popular prefix in the mid level |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Command accepted |
| cmd_op | output | 2 | 0 install, 1 remove, 2 evict, 3 mark cached |
| cmd_lvl | output | 2 | Target level: 0 fast, 1 mid, 2 slow table |
| cmd_idx | output | IDX_W | Prefix index of the command |

## Verification
The bench drives both levels into the full state, so that the threshold switches to its steady-state value and every later promotion must start with an eviction. A design that checks fullness after the install, or that uses one threshold for both levels, would issue a command one match too early or too late. A victim is first given a count just below the threshold and then hit again after its eviction. Any command issued in that second run would show a victim count that was never cleared. A window tick placed inside a run of matches works the same way: a count that survives the tick promotes early. Commands are held off with `cmd_ready` low, which shows whether `hit_ready` leaks high or the command fields drift while the sequence is stalled.

// File: rtl/promo_pkg.sv
package promo_pkg;
    typedef enum logic [1:0] {
        LVL_FAST = 2'd0,
        LVL_MID  = 2'd1,
        LVL_SLOW = 2'd2,
        LVL_NONE = 2'd3
    } lvl_e;

    typedef enum logic [1:0] {
        OP_INSTALL = 2'd0,
        OP_REMOVE  = 2'd1,
        OP_EVICT   = 2'd2,
        OP_MARK    = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVICT,
        ST_REMOVE,
        ST_INSTALL,
        ST_MARK
    } state_e;
endpackage

// File: rtl/promo_cnt_bank.sv
module promo_cnt_bank #(
    parameter int IDX_W = 4,
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic             inc_en,
    input  logic [IDX_W-1:0] inc_idx,
    input  logic             clr_a_en,
    input  logic [IDX_W-1:0] clr_a_idx,
    input  logic             clr_b_en,
    input  logic [IDX_W-1:0] clr_b_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_cnt
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        localparam logic [IDX_W-1:0] SLOT = IDX_W'(g);
        logic hit_a, hit_b, hit_i;
        assign hit_a = clr_a_en && (clr_a_idx == SLOT);
        assign hit_b = clr_b_en && (clr_b_idx == SLOT);
        assign hit_i = inc_en && (inc_idx == SLOT);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q[g] <= '0;
            end else if (clr_all || hit_a || hit_b) begin
                cnt_q[g] <= '0;
            end else if (hit_i && (cnt_q[g] != CNT_MAX)) begin
                cnt_q[g] <= cnt_q[g] + 1'b1;
            end
        end
    end

    assign rd_cnt = cnt_q[rd_idx];
endmodule

// File: rtl/promo_occ.sv
module promo_occ #(
    parameter int CAP   = 20000,
    parameter int OCC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [OCC_W-1:0] occ,
    output logic             full
);
    localparam logic [OCC_W-1:0] CAP_V = OCC_W'(CAP);

    logic [OCC_W-1:0] occ_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else if (inc && !dec && (occ_q != CAP_V)) begin
            occ_q <= occ_q + 1'b1;
        end else if (dec && !inc && (occ_q != '0)) begin
            occ_q <= occ_q - 1'b1;
        end
    end

    assign occ  = occ_q;
    assign full = (occ_q >= CAP_V);
endmodule

// File: rtl/promo_thresh.sv
module promo_thresh #(
    parameter int CNT_W        = 9,
    parameter int FAST_TH_WARM = 15,
    parameter int FAST_TH_HOT  = 300,
    parameter int MID_TH_WARM  = 1,
    parameter int MID_TH_HOT   = 100
) (
    input  logic             src_is_mid,
    input  logic             fast_full,
    input  logic             mid_full,
    output logic [CNT_W-1:0] thresh,
    output logic             dst_full
);
    localparam logic [CNT_W-1:0] FW = CNT_W'(FAST_TH_WARM);
    localparam logic [CNT_W-1:0] FH = CNT_W'(FAST_TH_HOT);
    localparam logic [CNT_W-1:0] MW = CNT_W'(MID_TH_WARM);
    localparam logic [CNT_W-1:0] MH = CNT_W'(MID_TH_HOT);

    always_comb begin
        if (src_is_mid) begin
            dst_full = fast_full;
            thresh   = fast_full ? FH : FW;
        end else begin
            dst_full = mid_full;
            thresh   = mid_full ? MH : MW;
        end
    end
endmodule

// File: rtl/route_promo_ctrl.sv
module route_promo_ctrl
    import promo_pkg::*;
#(
    parameter int IDX_W        = 4,
    parameter int FAST_CAP     = 20000,
    parameter int MID_CAP      = 40000,
    parameter int FAST_TH_WARM = 15,
    parameter int FAST_TH_HOT  = 300,
    parameter int MID_TH_WARM  = 1,
    parameter int MID_TH_HOT   = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_min,
    input  logic             hit_valid,
    output logic             hit_ready,
    input  logic [IDX_W-1:0] hit_idx,
    input  logic [1:0]       hit_lvl,
    input  logic [IDX_W-1:0] fast_victim,
    input  logic [IDX_W-1:0] mid_victim,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [1:0]       cmd_op,
    output logic [1:0]       cmd_lvl,
    output logic [IDX_W-1:0] cmd_idx
);
    localparam int TH_A   = (FAST_TH_WARM > FAST_TH_HOT) ? FAST_TH_WARM : FAST_TH_HOT;
    localparam int TH_B   = (MID_TH_WARM > MID_TH_HOT) ? MID_TH_WARM : MID_TH_HOT;
    localparam int TH_MAX = (TH_A > TH_B) ? TH_A : TH_B;
    localparam int CNT_W  = $clog2(TH_MAX + 1);
    localparam int CAP_MX = (FAST_CAP > MID_CAP) ? FAST_CAP : MID_CAP;
    localparam int OCC_W  = $clog2(CAP_MX + 1);
    localparam int NLVL   = 2;

    state_e state_q, state_d;

    logic [IDX_W-1:0] pr_idx_q, vic_q;
    logic             src_mid_q, need_ev_q;

    logic             hit_fire, cmd_fire, counted, src_is_mid, promote;
    logic [CNT_W-1:0] cur_cnt, nxt_cnt, thresh;
    logic             dst_full;

    logic [OCC_W-1:0] occ_lv [NLVL];
    logic             full_lv [NLVL];
    logic             occ_inc [NLVL];
    logic             occ_dec [NLVL];
    logic [OCC_W-1:0] f_occ, m_occ;

    assign hit_ready  = (state_q == ST_IDLE);
    assign hit_fire   = hit_valid && hit_ready;
    assign cmd_fire   = cmd_valid && cmd_ready;
    assign src_is_mid = (hit_lvl == LVL_MID);
    assign counted    = (hit_lvl == LVL_MID) || (hit_lvl == LVL_SLOW);
    assign nxt_cnt    = (cur_cnt == '1) ? cur_cnt : cur_cnt + 1'b1;
    assign promote    = counted && (nxt_cnt >= thresh);

    promo_cnt_bank #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_all   (tick_min),
        .inc_en    (hit_fire && counted && !promote),
        .inc_idx   (hit_idx),
        .clr_a_en  (hit_fire && promote),
        .clr_a_idx (hit_idx),
        .clr_b_en  (cmd_fire && (state_q == ST_EVICT)),
        .clr_b_idx (vic_q),
        .rd_idx    (hit_idx),
        .rd_cnt    (cur_cnt)
    );

    promo_thresh #(
        .CNT_W(CNT_W), .FAST_TH_WARM(FAST_TH_WARM), .FAST_TH_HOT(FAST_TH_HOT),
        .MID_TH_WARM(MID_TH_WARM), .MID_TH_HOT(MID_TH_HOT)
    ) u_th (
        .src_is_mid (src_is_mid),
        .fast_full  (full_lv[0]),
        .mid_full   (full_lv[1]),
        .thresh     (thresh),
        .dst_full   (dst_full)
    );

    // level 0 is the fast cache, level 1 the mid cache
    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        promo_occ #(
            .CAP   ((g == 0) ? FAST_CAP : MID_CAP),
            .OCC_W (OCC_W)
        ) u_occ (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (occ_inc[g]),
            .dec   (occ_dec[g]),
            .occ   (occ_lv[g]),
            .full  (full_lv[g])
        );
    end

    assign f_occ = occ_lv[0];
    assign m_occ = occ_lv[1];

    always_comb begin
        occ_inc[0] = cmd_fire && (state_q == ST_INSTALL) && src_mid_q;
        occ_dec[0] = cmd_fire && (state_q == ST_EVICT) && src_mid_q;
        occ_inc[1] = cmd_fire && (state_q == ST_INSTALL) && !src_mid_q;
        occ_dec[1] = cmd_fire && (((state_q == ST_EVICT) && !src_mid_q)
                                  || (state_q == ST_REMOVE));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pr_idx_q  <= '0;
            vic_q     <= '0;
            src_mid_q <= 1'b0;
            need_ev_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (hit_fire && promote) begin
                pr_idx_q  <= hit_idx;
                src_mid_q <= src_is_mid;
                need_ev_q <= dst_full;
                vic_q     <= src_is_mid ? fast_victim : mid_victim;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (hit_fire && promote) begin
                    if (dst_full)        state_d = ST_EVICT;
                    else if (src_is_mid) state_d = ST_REMOVE;
                    else                 state_d = ST_INSTALL;
                end
            end
            ST_EVICT: begin
                if (cmd_fire) state_d = src_mid_q ? ST_REMOVE : ST_INSTALL;
            end
            ST_REMOVE: begin
                if (cmd_fire) state_d = ST_INSTALL;
            end
            ST_INSTALL: begin
                if (cmd_fire) state_d = src_mid_q ? ST_IDLE : ST_MARK;
            end
            ST_MARK: begin
                if (cmd_fire) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_valid = 1'b1;
        cmd_op    = OP_INSTALL;
        cmd_lvl   = src_mid_q ? LVL_FAST : LVL_MID;
        cmd_idx   = pr_idx_q;
        unique case (state_q)
            ST_IDLE: begin
                cmd_valid = 1'b0;
            end
            ST_EVICT: begin
                cmd_op  = OP_EVICT;
                cmd_idx = vic_q;
            end
            ST_REMOVE: begin
                cmd_op  = OP_REMOVE;
                cmd_lvl = LVL_MID;
            end
            ST_INSTALL: begin
                cmd_op = OP_INSTALL;
            end
            ST_MARK: begin
                cmd_op  = OP_MARK;
                cmd_lvl = LVL_SLOW;
            end
            default: cmd_valid = 1'b0;
        endcase
    end

    logic unused_ok;
    assign unused_ok = need_ev_q;
endmodule

// File: rtl/promo_ctrl_chk.sv
module promo_ctrl_chk #(
    parameter int IDX_W    = 4,
    parameter int OCC_W    = 16,
    parameter int FAST_CAP = 20000,
    parameter int MID_CAP  = 40000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hit_ready,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [1:0]       cmd_op,
    input logic [1:0]       cmd_lvl,
    input logic [IDX_W-1:0] cmd_idx,
    input logic [OCC_W-1:0] f_occ,
    input logic [OCC_W-1:0] m_occ
);
    localparam logic [OCC_W-1:0] FCAP = OCC_W'(FAST_CAP);
    localparam logic [OCC_W-1:0] MCAP = OCC_W'(MID_CAP);

    logic fire;
    assign fire = cmd_valid && cmd_ready;

    p_fast_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        f_occ <= FCAP);
    p_mid_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        m_occ <= MCAP);
    p_fast_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd0 && cmd_lvl == 2'd0) |-> (f_occ < FCAP));
    p_mid_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd0 && cmd_lvl == 2'd1) |-> (m_occ < MCAP));
    p_evict_pairs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cmd_op == 2'd2) |=> (cmd_valid && cmd_op != 2'd2));
    p_one_at_a_time_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !hit_ready);
    p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=>
            (cmd_valid && $stable(cmd_op) && $stable(cmd_lvl) && $stable(cmd_idx)));
    p_remove_then_install_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cmd_op == 2'd1) |=>
            (cmd_valid && cmd_op == 2'd0 && cmd_lvl == 2'd0 && cmd_idx == $past(cmd_idx)));
    p_install_then_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cmd_op == 2'd0 && cmd_lvl == 2'd1) |=>
            (cmd_valid && cmd_op == 2'd3 && cmd_lvl == 2'd2 && cmd_idx == $past(cmd_idx)));
endmodule

bind route_promo_ctrl promo_ctrl_chk #(
    .IDX_W(IDX_W), .OCC_W(OCC_W), .FAST_CAP(FAST_CAP), .MID_CAP(MID_CAP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_ready (hit_ready),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_lvl   (cmd_lvl),
    .cmd_idx   (cmd_idx),
    .f_occ     (f_occ),
    .m_occ     (m_occ)
);

// File: tb/route_promo_ctrl_bench.sv
module route_promo_ctrl_bench;
    localparam int IDX_W = 4;
    localparam int FC = 2, MC = 2;
    localparam int FTW = 3, FTH = 5, MTW = 1, MTH = 3;
    localparam int NROW = 14;

    // row: {tick, lvl[1:0], idx[3:0], victim[3:0], repeat[3:0]}
    localparam logic [14:0] TBL [NROW] = '{
        {1'b0, 2'd2, 4'd1, 4'd0, 4'd1},   // R1 warm mid fill
        {1'b0, 2'd2, 4'd2, 4'd0, 4'd1},   // R1 mid now full
        {1'b0, 2'd2, 4'd3, 4'd1, 4'd3},   // R3 hot mid threshold, R4 evict mid 1
        {1'b0, 2'd1, 4'd2, 4'd0, 4'd3},   // R2 warm fast threshold
        {1'b0, 2'd1, 4'd3, 4'd0, 4'd3},   // R2 fast now full
        {1'b0, 2'd0, 4'd5, 4'd0, 4'd4},   // R9 fast hits ignored
        {1'b0, 2'd2, 4'd4, 4'd0, 4'd1},   // R1
        {1'b0, 2'd2, 4'd6, 4'd0, 4'd1},   // R1 mid full again
        {1'b0, 2'd1, 4'd7, 4'd0, 4'd4},   // R3 below hot fast threshold
        {1'b0, 2'd1, 4'd4, 4'd7, 4'd5},   // R4 R5 evict fast 7
        {1'b0, 2'd1, 4'd7, 4'd2, 4'd4},   // R7 victim count was cleared
        {1'b1, 2'd1, 4'd7, 4'd2, 4'd1},   // R6 tick clears counts
        {1'b0, 2'd1, 4'd7, 4'd2, 4'd4},   // R6 promote after fresh window
        {1'b0, 2'd2, 4'd8, 4'd0, 4'd1}    // R5 mid drained, warm again
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_min = 1'b0;
    logic             hit_valid = 1'b0;
    logic             hit_ready;
    logic [IDX_W-1:0] hit_idx = '0;
    logic [1:0]       hit_lvl = '0;
    logic [IDX_W-1:0] fast_victim = '0;
    logic [IDX_W-1:0] mid_victim = '0;
    logic             cmd_valid;
    logic             cmd_ready = 1'b0;
    logic [1:0]       cmd_op;
    logic [1:0]       cmd_lvl;
    logic [IDX_W-1:0] cmd_idx;

    int total = 0;
    int bad = 0;
    int cnt_m [16];
    int focc = 0, mocc = 0;
    string rtag [NROW] = '{"R1", "R1", "R3 R4", "R2", "R2", "R9", "R1", "R1",
                           "R3", "R4 R5", "R7", "R6", "R6", "R5"};

    always #5 clk = ~clk;

    route_promo_ctrl #(
        .IDX_W(IDX_W), .FAST_CAP(FC), .MID_CAP(MC),
        .FAST_TH_WARM(FTW), .FAST_TH_HOT(FTH),
        .MID_TH_WARM(MTW), .MID_TH_HOT(MTH)
    ) u_route_promo_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_min(tick_min),
        .hit_valid(hit_valid), .hit_ready(hit_ready),
        .hit_idx(hit_idx), .hit_lvl(hit_lvl),
        .fast_victim(fast_victim), .mid_victim(mid_victim),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_lvl(cmd_lvl), .cmd_idx(cmd_idx)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_hit(input logic [3:0] idx, input logic [1:0] lvl);
        @(negedge clk);
        hit_valid = 1'b1;
        hit_idx   = idx;
        hit_lvl   = lvl;
        @(negedge clk);
        hit_valid = 1'b0;
    endtask

    task automatic expect_none(input string tag);
        check(!cmd_valid, {tag, " no command"}, cmd_valid, 0);
        @(negedge clk);
        check(!cmd_valid && hit_ready, {tag, " still idle"}, {cmd_valid, hit_ready}, 1);
    endtask

    task automatic expect_cmd(input logic [1:0] op, input logic [1:0] lvl,
                              input logic [3:0] idx, input string tag);
        int n = 0;
        logic [7:0] got;
        while (!cmd_valid && n < 20) begin
            @(negedge clk);
            n++;
        end
        got = {cmd_op, cmd_lvl, cmd_idx};
        check(got == {op, lvl, idx}, {tag, " command op/lvl/idx"}, got, {op, lvl, idx});
        // R8: stall the command and watch it hold
        repeat (2) begin
            @(negedge clk);
            check(cmd_valid && !hit_ready && ({cmd_op, cmd_lvl, cmd_idx} == got),
                  "R8 hold while stalled", {cmd_valid, hit_ready, cmd_op, cmd_lvl, cmd_idx},
                  {2'b10, got});
        end
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
    endtask

    task automatic run_row(input int r);
        logic        tk;
        logic [1:0]  lvl;
        logic [3:0]  idx, vic, rep;
        {tk, lvl, idx, vic, rep} = TBL[r];
        fast_victim = vic;
        mid_victim  = vic;
        if (tk) begin
            @(negedge clk);
            tick_min = 1'b1;
            @(negedge clk);
            tick_min = 1'b0;
            for (int k = 0; k < 16; k++) cnt_m[k] = 0;
        end
        for (int k = 0; k < int'(rep); k++) begin
            do_hit(idx, lvl);
            if (lvl == 2'd1 || lvl == 2'd2) begin
                int  c  = cnt_m[idx] + 1;
                bit  fl = (lvl == 2'd1) ? (focc >= FC) : (mocc >= MC);
                int  th = (lvl == 2'd1) ? (fl ? FTH : FTW) : (fl ? MTH : MTW);
                logic [1:0] dst = (lvl == 2'd1) ? 2'd0 : 2'd1;
                if (c >= th) begin
                    cnt_m[idx] = 0;
                    if (fl) begin
                        expect_cmd(2'd2, dst, vic, rtag[r]);
                        cnt_m[vic] = 0;
                        if (dst == 2'd0) focc--; else mocc--;
                    end
                    if (lvl == 2'd1) begin
                        expect_cmd(2'd1, 2'd1, idx, rtag[r]);
                        mocc--;
                    end
                    expect_cmd(2'd0, dst, idx, rtag[r]);
                    if (dst == 2'd0) focc++; else mocc++;
                    if (lvl == 2'd2) expect_cmd(2'd3, 2'd2, idx, rtag[r]);
                end else begin
                    cnt_m[idx] = c;
                    expect_none(rtag[r]);
                end
            end else begin
                expect_none(rtag[r]);
            end
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        for (int k = 0; k < 16; k++) cnt_m[k] = 0;
        repeat (3) @(negedge clk);
        check(hit_ready && !cmd_valid, "R8 reset state", {hit_ready, cmd_valid}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        check(hit_ready && !cmd_valid, "R8 after reset", {hit_ready, cmd_valid}, 2'b10);

        for (int r = 0; r < NROW; r++) run_row(r);

        // R9: level code 3 is ignored as well
        do_hit(4'd9, 2'd3);
        expect_none("R9 code 3");
        // R6: tick in the same cycle as an accepted slow hit; mid not full so warm 1
        @(negedge clk);
        tick_min  = 1'b1;
        hit_valid = 1'b1;
        hit_idx   = 4'd10;
        hit_lvl   = 2'd2;
        @(negedge clk);
        tick_min  = 1'b0;
        hit_valid = 1'b0;
        expect_cmd(2'd0, 2'd1, 4'd10, "R1 R6 tick with hit");
        expect_cmd(2'd3, 2'd2, 4'd10, "R1 R6 tick with hit");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule